// File: doc/BRIEF.md
# Potentiometer Command Slave on a Two-Wire Bus

This block is the serial front end of a dual-channel, 8-bit programmable resistor controller. It watches the two bus wires (clock and data) through synchronizers running on a faster system clock. It spots start and stop conditions and answers to one 7-bit address. That address is a fixed five-bit prefix followed by two strap pins. The block pulls the data line low through an open-drain enable to acknowledge and to return data.

A write carries an instruction byte and then any number of data bytes. The instruction selects a channel and carries the midscale-reset, shutdown and two general-purpose output bits. Each data byte becomes a write strobe toward the register block, under the instruction already received. A read carries no pointer. It returns the register value that the register block presents for the channel chosen by the most recent instruction. It keeps sending bytes while the master acknowledges and stops at the master's NACK.

Top module: `pot_i2c_slave`

## Requirements
- R1: The block acknowledges only the address whose upper five bits are 01011 and whose next two bits equal strap[1] then strap[0]; bit 0 of the address byte is 1 for read and 0 for write. On any other address it leaves SDA released, issues no strobe and ignores traffic until the next start or stop.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start in any state, including the middle of a byte, begins a fresh address byte.
- R3: The first byte after a write address is the instruction, MSB first: bit 7 channel (0 = first, 1 = second), bit 6 midscale reset, bit 5 shutdown, bit 4 output one, bit 3 output two; bits 2..0 are ignored. On its eighth bit the fields appear on cmd_chan, cmd_midrst, cmd_shdn, cmd_o1 and cmd_o2, and cmd_stb pulses for one clock.
- R4: Every full byte after the instruction, up to the next start or stop, pulses wr_stb for one clock with the byte on wr_data, and all of them fall under the same instruction.
- R5: The addressed slave pulls SDA low during the ninth clock of each byte it receives (address, instruction, data). SDA is changed only after SCL has fallen.
- R6: In a read, the byte from rd_data goes out MSB first straight after the address acknowledge. A master ACK brings a further byte, and a master NACK ends the read with SDA released.
- R7: A write that stops after the instruction byte updates the command fields but issues no wr_stb.
- R8: A repeated start after the instruction byte may switch to a read, which returns the channel that instruction just selected.
- R9: A start or stop inside a byte discards that byte: no cmd_stb and no wr_stb comes from it.
- R10: After reset SDA is released, no strobe is active and every command field is 0.
- R11: The channel selection persists across transactions until another instruction byte changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire as seen on the pad |
| sda_i | input | 1 | Bus data wire as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data wire low |
| strap | input | STRAP_W (2) | Address strap pins, strap[1] is the higher address bit |
| rd_data | input | DATA_W (8) | Register value of the selected channel from the register block |
| cmd_stb | output | 1 | One-clock pulse when an instruction byte is complete |
| cmd_chan | output | 1 | Selected channel |
| cmd_midrst | output | 1 | Midscale-reset request field |
| cmd_shdn | output | 1 | Shutdown field |
| cmd_o1 | output | 1 | General-purpose output one |
| cmd_o2 | output | 1 | General-purpose output two |
| wr_stb | output | 1 | One-clock pulse per complete data byte |
| wr_data | output | DATA_W (8) | Received data byte |

## Verification
The bench builds the block with three synchronizer stages instead of the default two and with the straps tied to 10. The longer reaction delay is then checked against the bus phase length, and a strap mismatch can be tested on each address bit. With 8 system clocks per quarter SCL period, the acknowledge and read bits settle well before the master samples them. Start and stop conditions can also be placed between any two bit clocks, which brings the mid-byte abort and the repeated-start cases within reach.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_INSTR,
      ST_DATA,
      ST_ACK,
      ST_READ,
      ST_RACK,
      ST_SKIP
   } pot_state_t;

   // Instruction fields, most significant first as they arrive on the wire
   typedef struct packed {
      logic chan;
      logic midrst;
      logic shdn;
      logic o1;
      logic o2;
   } pot_instr_t;

   localparam int INSTR_FIELDS = $bits(pot_instr_t);

endpackage

// File: rtl/pot_i2c_sync.sv
module pot_i2c_sync #(
   parameter int                WIDTH   = 2,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pot_i2c_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pot_i2c_bus_cond.sv
module pot_i2c_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start,
   output logic stop,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // Conditions need SCL high on both samples so a clock edge is never mistaken
   assign start    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop     = scl_s & scl_q & ~sda_q & sda_s;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/pot_i2c_ctrl.sv
module pot_i2c_ctrl
   import pot_i2c_pkg::*;
#(
   parameter int                              DATA_W      = 8,
   parameter int                              STRAP_W     = 2,
   parameter logic [DATA_W-STRAP_W-2:0]       ADDR_PREFIX = 5'b01011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               start,
   input  logic               stop,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic [STRAP_W-1:0] strap,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               sda_oe,
   output logic               cmd_stb,
   output pot_instr_t         cmd,
   output logic               wr_stb,
   output logic [DATA_W-1:0]  wr_data
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   pot_state_t          state, after_ack;
   logic [CNT_W-1:0]    cnt;
   logic [DATA_W-1:0]   shreg;
   logic [DATA_W-1:0]   rx_byte;
   logic                byte_full;
   logic                master_ack;
   logic                last_bit;
   logic                addr_hit;

   assign rx_byte  = {shreg[DATA_W-2:0], sda_s};
   assign last_bit = (cnt == LAST);
   assign addr_hit = (rx_byte[DATA_W-1:1] == {ADDR_PREFIX, strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         after_ack  <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         byte_full  <= 1'b0;
         master_ack <= 1'b0;
         sda_oe     <= 1'b0;
         cmd_stb    <= 1'b0;
         cmd        <= '0;
         wr_stb     <= 1'b0;
         wr_data    <= '0;
      end else begin
         cmd_stb <= 1'b0;
         wr_stb  <= 1'b0;
         if (stop) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            cnt       <= '0;
            byte_full <= 1'b0;
         end else if (start) begin
            state     <= ST_ADDR;
            sda_oe    <= 1'b0;
            cnt       <= '0;
            byte_full <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_INSTR, ST_DATA: begin
                  if (byte_full) begin
                     if (scl_fall) begin
                        state     <= ST_ACK;
                        sda_oe    <= 1'b1;
                        byte_full <= 1'b0;
                     end
                  end else if (scl_rise) begin
                     shreg <= rx_byte;
                     if (!last_bit) begin
                        cnt <= cnt + 1'b1;
                     end else begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                           if (addr_hit) begin
                              byte_full <= 1'b1;
                              after_ack <= rx_byte[0] ? ST_READ : ST_INSTR;
                           end else begin
                              state <= ST_SKIP;
                           end
                        end else if (state == ST_INSTR) begin
                           byte_full <= 1'b1;
                           cmd       <= pot_instr_t'(rx_byte[DATA_W-1 -: INSTR_FIELDS]);
                           cmd_stb   <= 1'b1;
                           after_ack <= ST_DATA;
                        end else begin
                           byte_full <= 1'b1;
                           wr_data   <= rx_byte;
                           wr_stb    <= 1'b1;
                           after_ack <= ST_DATA;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     state <= after_ack;
                     cnt   <= '0;
                     if (after_ack == ST_READ) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_READ: begin
                  if (scl_fall) begin
                     if (last_bit) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RACK;
                     end else begin
                        cnt    <= cnt + 1'b1;
                        shreg  <= {shreg[DATA_W-2:0], shreg[DATA_W-1]};
                        sda_oe <= ~shreg[DATA_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     master_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (master_ack) begin
                        state  <= ST_READ;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);

   assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   assert_oe_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> ($past(scl_fall) || $past(start) || $past(stop)));

   assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (state == ST_ADDR) && !sda_oe);

   assert_skip_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

   assert_abort_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start || stop) |=> !wr_stb && !cmd_stb);

endmodule

// File: rtl/pot_i2c_slave.sv
module pot_i2c_slave
   import pot_i2c_pkg::*;
#(
   parameter int                         SYNC_STAGES = 2,
   parameter int                         DATA_W      = 8,
   parameter int                         STRAP_W     = 2,
   parameter logic [DATA_W-STRAP_W-2:0]  ADDR_PREFIX = 5'b01011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               cmd_stb,
   output logic               cmd_chan,
   output logic               cmd_midrst,
   output logic               cmd_shdn,
   output logic               cmd_o1,
   output logic               cmd_o2,
   output logic               wr_stb,
   output logic [DATA_W-1:0]  wr_data
);

   if (DATA_W < INSTR_FIELDS) begin : g_bad_width
      $error("pot_i2c_slave: DATA_W too narrow for the instruction fields");
   end

   logic       scl_s, sda_s;
   logic       start, stop, scl_rise, scl_fall;
   pot_instr_t cmd;

   pot_i2c_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_s, sda_s})
   );

   pot_i2c_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .start    (start),
      .stop     (stop),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall)
   );

   pot_i2c_ctrl #(
      .DATA_W      (DATA_W),
      .STRAP_W     (STRAP_W),
      .ADDR_PREFIX (ADDR_PREFIX)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_s    (sda_s),
      .start    (start),
      .stop     (stop),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .strap    (strap),
      .rd_data  (rd_data),
      .sda_oe   (sda_oe),
      .cmd_stb  (cmd_stb),
      .cmd      (cmd),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data)
   );

   assign cmd_chan   = cmd.chan;
   assign cmd_midrst = cmd.midrst;
   assign cmd_shdn   = cmd.shdn;
   assign cmd_o1     = cmd.o1;
   assign cmd_o2     = cmd.o2;

   // R10: nothing is driven onto the bus while reset is held
   always_comb begin
      if (!rst_n) assert_reset_quiet_R10: assert (!sda_oe && !wr_stb && !cmd_stb);
   end

endmodule

// File: tb/pot_i2c_slave_tb.sv
module pot_i2c_slave_tb;

   localparam int Q = 8;
   localparam logic [6:0] MY_ADDR = 7'h2E;

   // {address[6:0], instruction[7:0], data[7:0], expect_ack}
   localparam logic [23:0] VEC [6] = '{
      {7'h2E, 8'h00, 8'h3C, 1'b1},
      {7'h2E, 8'h90, 8'hA5, 1'b1},
      {7'h2D, 8'h80, 8'h11, 1'b0},
      {7'h2E, 8'h28, 8'hFF, 1'b1},
      {7'h6E, 8'h00, 8'h00, 1'b0},
      {7'h2E, 8'h87, 8'h01, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_oe;
   logic [7:0] rd_data;
   logic cmd_stb, cmd_chan, cmd_midrst, cmd_shdn, cmd_o1, cmd_o2;
   logic wr_stb;
   logic [7:0] wr_data;

   int n_tests = 0;
   int n_fail  = 0;
   int wr_cnt, cmd_cnt;
   logic [7:0] last_wr;
   logic [7:0] model0, model1;

   logic [23:0] v;
   logic a1, a2, a3, dummy;
   logic [7:0] rd;
   int w0, c0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   assign rd_data  = cmd_chan ? model1 : model0;

   pot_i2c_slave #(.SYNC_STAGES(3)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe),
      .strap      (2'b10),
      .rd_data    (rd_data),
      .cmd_stb    (cmd_stb),
      .cmd_chan   (cmd_chan),
      .cmd_midrst (cmd_midrst),
      .cmd_shdn   (cmd_shdn),
      .cmd_o1     (cmd_o1),
      .cmd_o2     (cmd_o2),
      .wr_stb     (wr_stb),
      .wr_data    (wr_data)
   );

   // Register-block model and strobe monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         wr_cnt = 0; cmd_cnt = 0; last_wr = 8'h00;
         model0 = 8'h80; model1 = 8'h80;
      end else begin
         if (wr_stb) begin
            wr_cnt++;
            last_wr = wr_data;
            if (cmd_chan) model1 = wr_data; else model0 = wr_data;
         end
         if (cmd_stb) begin
            cmd_cnt++;
            if (cmd_midrst) begin
               if (cmd_chan) model1 = 8'h80; else model0 = 8'h80;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait();
   endtask

   task automatic clk_bit(input logic b, output logic seen);
      sda_m = b;    qwait();
      scl_m = 1'b1; qwait();
      seen = sda_line; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      d = 8'h00;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         d = {d[6:0], s};
      end
      clk_bit(give_ack ? 1'b0 : 1'b1, s);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: reset state
      chk("R10 sda_oe in reset", sda_oe, 0);
      chk("R10 strobes in reset", {wr_stb, cmd_stb}, 0);
      chk("R10 fields in reset", {cmd_chan, cmd_midrst, cmd_shdn, cmd_o1, cmd_o2}, 0);
      rst_n = 1'b1;
      qwait();

      // Vector table: writes to matching and non-matching addresses (R1 R3 R4 R5)
      for (int i = 0; i < 6; i++) begin
         v  = VEC[i];
         w0 = wr_cnt;
         c0 = cmd_cnt;
         bus_start();
         send_byte({v[23:17], 1'b0}, a1);
         send_byte(v[16:9], a2);
         send_byte(v[8:1], a3);
         bus_stop();
         chk("R1 R5 address ack", a1, v[0]);
         chk("R5 instruction ack", a2, v[0]);
         chk("R5 data ack", a3, v[0]);
         chk("R4 write count", wr_cnt - w0, v[0] ? 1 : 0);
         chk("R1 R3 instruction count", cmd_cnt - c0, v[0] ? 1 : 0);
         if (v[0]) begin
            chk("R4 data value", last_wr, v[8:1]);
            chk("R3 fields", {cmd_chan, cmd_midrst, cmd_shdn, cmd_o1, cmd_o2}, v[16:12]);
         end
         chk("R1 released after stop", sda_oe, 0);
      end

      // R6 R11: read returns second channel still selected from the last instruction
      bus_start();
      send_byte({MY_ADDR, 1'b1}, a1);
      recv_byte(1'b0, rd);
      bus_stop();
      chk("R6 read ack", a1, 1);
      chk("R11 R6 read selected channel", rd, 8'h01);
      chk("R6 released after NACK", sda_oe, 0);

      // R4: several data bytes under one instruction
      w0 = wr_cnt; c0 = cmd_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h00, a2);
      send_byte(8'h11, a3);
      send_byte(8'h22, a3);
      send_byte(8'h33, a3);
      bus_stop();
      chk("R4 burst write count", wr_cnt - w0, 3);
      chk("R4 burst single instruction", cmd_cnt - c0, 1);
      chk("R4 burst last value", last_wr, 8'h33);

      // R6: master ACK fetches another byte
      bus_start();
      send_byte({MY_ADDR, 1'b1}, a1);
      recv_byte(1'b1, rd);
      chk("R6 first read byte", rd, 8'h33);
      recv_byte(1'b0, rd);
      chk("R6 second read byte", rd, 8'h33);
      bus_stop();

      // R7: instruction only
      w0 = wr_cnt; c0 = cmd_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h98, a2);
      bus_stop();
      chk("R7 no data write", wr_cnt - w0, 0);
      chk("R7 instruction taken", cmd_cnt - c0, 1);
      chk("R7 fields", {cmd_chan, cmd_midrst, cmd_shdn, cmd_o1, cmd_o2}, 5'b10011);

      // R8: write instruction then repeated start into a read, both channels
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h00, a2);
      bus_start();
      send_byte({MY_ADDR, 1'b1}, a3);
      recv_byte(1'b0, rd);
      bus_stop();
      chk("R8 ack after repeated start", a3, 1);
      chk("R8 read first channel", rd, 8'h33);
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h80, a2);
      bus_start();
      send_byte({MY_ADDR, 1'b1}, a3);
      recv_byte(1'b0, rd);
      bus_stop();
      chk("R8 read second channel", rd, 8'h01);

      // R3: midscale reset field
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h40, a2);
      bus_stop();
      chk("R3 midscale field", {cmd_chan, cmd_midrst}, 2'b01);

      // R9: stop inside a data byte
      w0 = wr_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(8'h00, a2);
      clk_bit(1'b1, dummy);
      clk_bit(1'b0, dummy);
      clk_bit(1'b1, dummy);
      clk_bit(1'b0, dummy);
      bus_stop();
      chk("R9 partial data dropped", wr_cnt - w0, 0);

      // R2 R9: start inside an instruction byte restarts addressing
      c0 = cmd_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      clk_bit(1'b1, dummy);
      clk_bit(1'b1, dummy);
      clk_bit(1'b1, dummy);
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a2);
      send_byte(8'h80, a3);
      bus_stop();
      chk("R2 address after mid-byte start", a2, 1);
      chk("R9 partial instruction dropped", cmd_cnt - c0, 1);
      chk("R2 new channel", cmd_chan, 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule